// File: doc/BRIEF.md
# EEPROM Page Buffer Commit Controller

This block sits behind a serial-bus front end inside a byte-addressed non-volatile memory. The front end hands it a write command carrying a starting word address, then a stream of data bytes, then an end-of-transfer strobe. The bytes are held in a 64-byte page buffer, and the pointer inside it only ever moves within the current page. When the transfer ends, the block rewrites the complete physical page into the memory array through a byte-wide write port. It does so one byte per clock in ascending offset order. Any byte that was not received is first fetched from the array through a read port with one cycle of latency, so its old value is written back unchanged.

A fixed region at the top of the address space, starting at 7000h by default, cannot be written: a transfer aimed at a page in that region ends quietly with no array access. After each real commit, a busy flag stays up for a programmable number of cycles that stands in for the cell programming time. The front end uses this flag to withhold acknowledges, and while it is high every strobe from the front end is ignored.

Top module: `eeprom_page_commit`

## Requirements
- R1: Each accepted data byte is stored at the current in-page offset, after which only the low 6 bits of the pointer advance by one; the page number (address bits 14:6) stays at the value taken from the command address.
- R2: When more than 64 bytes arrive in one transfer, the pointer wraps, and a later byte replaces the earlier byte held at the same offset.
- R3: A transfer that begins at a non-zero offset continues from offset 0 of the same page after offset 63, and never reaches the next page.
- R4: The array write port stays idle while bytes are being collected; a commit starts only on the end-of-transfer strobe.
- R5: A commit writes all 64 bytes of the page, one per clock, at offsets 0 to 63 in order. The write for offset 0 happens two clocks after the edge that samples the end strobe. Offsets that were not received are written with their current array contents.
- R6: When the page base address is 7000h or above, the end strobe causes no array write and busy stays low.
- R7: Busy rises in the first cycle after the end strobe is sampled and stays high for 65 + BUSY_CYCLES consecutive cycles.
- R8: While busy is high, command, data and end strobes are ignored and have no effect on the array.
- R9: A new command discards bytes collected under an earlier unfinished command. An end strobe with no data bytes since the last command, or a data byte with no open command, causes no commit.
- R10: After reset, busy is low and neither array port is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_start_i | input | 1 | Strobe: new write command with starting address |
| cmd_addr_i | input | ADDR_W (15) | Starting word address of the command |
| data_valid_i | input | 1 | Strobe: one data byte present |
| data_i | input | DATA_W (8) | Data byte |
| stop_i | input | 1 | Strobe: end of transfer, starts the commit |
| busy_o | output | 1 | Commit or write-time hold in progress |
| arr_re_o | output | 1 | Array read enable (data returns next cycle) |
| arr_raddr_o | output | ADDR_W (15) | Array read address |
| arr_rdata_i | input | DATA_W (8) | Array read data, one cycle after the read enable |
| arr_we_o | output | 1 | Array write enable |
| arr_waddr_o | output | ADDR_W (15) | Array write address |
| arr_wdata_o | output | DATA_W (8) | Array write data |

## Verification
The commit path is driven by four kinds of transfer: a short write at the start of a page, a short write that starts near the end of a page and wraps, an overlong burst of 66 bytes, and a command that is replaced before its end strobe. Together they separate a correct in-page wrap from one that carries into the next page, a whole-page refresh from a write of only the dirty bytes, and a buffer that is cleared on a new command from one that is not. Transfers to the last writable page and to the first protected page check the protection boundary exactly. Strobes sent during the hold period, and end strobes with no open command or no data, show that nothing can leak through while busy or with nothing buffered.

// File: rtl/epc_pkg.sv
package epc_pkg;
  typedef enum logic {
    SEQ_IDLE   = 1'b0,
    SEQ_COMMIT = 1'b1
  } epc_seq_e;
endpackage

// File: rtl/epc_page_buffer.sv
module epc_page_buffer #(
  parameter int PAGE_AW = 6,
  parameter int DATA_W  = 8,
  parameter int BASE_W  = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic [BASE_W-1:0]           load_base_i,
  input  logic [PAGE_AW-1:0]          load_off_i,
  input  logic                        push_i,
  input  logic [DATA_W-1:0]           push_data_i,
  input  logic [PAGE_AW-1:0]          rd_off_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic [(1<<PAGE_AW)-1:0]     dirty_o,
  output logic [BASE_W-1:0]           base_o
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;

  logic [PAGE_AW-1:0]           ptr_q, ptr_d;
  logic [BASE_W-1:0]            base_q, base_d;
  logic [PAGE_BYTES-1:0]        dirty_q, dirty_d;
  logic [PAGE_BYTES*DATA_W-1:0] store_w;

  always_comb begin
    ptr_d   = ptr_q;
    base_d  = base_q;
    dirty_d = dirty_q;
    if (load_i) begin
      ptr_d   = load_off_i;
      base_d  = load_base_i;
      dirty_d = '0;
    end else if (push_i) begin
      ptr_d          = ptr_q + 1'b1;
      dirty_d[ptr_q] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      base_q  <= '0;
      dirty_q <= '0;
    end else begin
      ptr_q   <= ptr_d;
      base_q  <= base_d;
      dirty_q <= dirty_d;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              slot_en;
    assign slot_en = push_i && !load_i && (ptr_q == PAGE_AW'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= push_data_i;
    end
    assign store_w[g*DATA_W +: DATA_W] = slot_q;
  end

  assign rd_data_o = store_w[rd_off_i*DATA_W +: DATA_W];
  assign dirty_o   = dirty_q;
  assign base_o    = base_q;

  // R1 / R2 / R3: pointer moves by one inside the page, wrapping modulo page size
  a_r1_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !load_i) |=> (ptr_q == PAGE_AW'($past(ptr_q) + 1)) && $stable(base_q));

  // R1: the byte just pushed is marked as received
  a_r1_mark_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !load_i) |=> dirty_q[$past(ptr_q)]);

  // R9: a new command discards the previous received set
  a_r9_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (dirty_q == '0));
endmodule

// File: rtl/epc_commit_seq.sv
module epc_commit_seq
  import epc_pkg::*;
#(
  parameter int PAGE_AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  output logic             commit_o,
  output logic [PAGE_AW:0] step_o,
  output logic             last_o
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;

  epc_seq_e         state_q, state_d;
  logic [PAGE_AW:0] step_q, step_d;

  assign last_o = (state_q == SEQ_COMMIT) && (step_q == (PAGE_AW+1)'(PAGE_BYTES));

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    case (state_q)
      SEQ_IDLE: begin
        if (go_i) begin
          state_d = SEQ_COMMIT;
          step_d  = '0;
        end
      end
      SEQ_COMMIT: begin
        if (last_o) begin
          state_d = SEQ_IDLE;
          step_d  = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign commit_o = (state_q == SEQ_COMMIT);
  assign step_o   = step_q;

  // R5: commit steps advance by exactly one per clock until the last one
  a_r5_step_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o && !last_o) |=> commit_o && (step_o == $past(step_o) + 1'b1));

  // R5: a commit always begins at step zero
  a_r5_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_o && go_i) |=> commit_o && (step_o == '0));
endmodule

// File: rtl/epc_busy_timer.sv
module epc_busy_timer #(
  parameter int BUSY_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic active_o
);
  localparam int CNT_W = (BUSY_CYCLES < 1) ? 1 : $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)            cnt_d = CNT_W'(BUSY_CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);

  // R7: the hold never exceeds the programmed length
  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BUSY_CYCLES));

  // R7: once running, the hold counts down one per clock
  a_r7_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit
  import epc_pkg::*;
#(
  parameter int          ADDR_W      = 15,
  parameter int          PAGE_AW     = 6,
  parameter int          DATA_W      = 8,
  parameter int          BUSY_CYCLES = 20,
  parameter int unsigned PROT_START  = 32'h7000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic              arr_re_o,
  output logic [ADDR_W-1:0] arr_raddr_o,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_waddr_o,
  output logic [DATA_W-1:0] arr_wdata_o
);
  localparam int BASE_W     = ADDR_W - PAGE_AW;
  localparam int PAGE_BYTES = 1 << PAGE_AW;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic                  commit_w, last_w, hold_w;
  logic [PAGE_AW:0]      step_w;
  logic [PAGE_AW-1:0]    rd_off_w, wr_off_w;
  logic [PAGE_BYTES-1:0] dirty_w;
  logic [BASE_W-1:0]     base_w;
  logic [DATA_W-1:0]     buf_byte_w;
  logic                  open_q, open_d;
  logic                  accept_w, start_acc_w, data_acc_w, stop_acc_w;
  logic                  prot_w, go_w;

  assign busy_o      = commit_w || hold_w;
  assign accept_w    = !busy_o;
  assign stop_acc_w  = accept_w && stop_i;
  assign start_acc_w = accept_w && cmd_start_i && !stop_i;
  assign data_acc_w  = accept_w && data_valid_i && !cmd_start_i && !stop_i && open_q;
  assign prot_w      = {base_w, {PAGE_AW{1'b0}}} >= ADDR_W'(PROT_START);
  assign go_w        = stop_acc_w && open_q && (dirty_w != '0) && !prot_w;

  always_comb begin
    open_d = open_q;
    if (stop_acc_w)       open_d = 1'b0;
    else if (start_acc_w) open_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) open_q <= 1'b0;
    else             open_q <= open_d;
  end

  epc_page_buffer #(
    .PAGE_AW (PAGE_AW),
    .DATA_W  (DATA_W),
    .BASE_W  (BASE_W)
  ) u_buffer (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .load_i      (start_acc_w),
    .load_base_i (cmd_addr_i[ADDR_W-1:PAGE_AW]),
    .load_off_i  (cmd_addr_i[PAGE_AW-1:0]),
    .push_i      (data_acc_w),
    .push_data_i (data_i),
    .rd_off_i    (wr_off_w),
    .rd_data_o   (buf_byte_w),
    .dirty_o     (dirty_w),
    .base_o      (base_w)
  );

  epc_commit_seq #(
    .PAGE_AW (PAGE_AW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .go_i     (go_w),
    .commit_o (commit_w),
    .step_o   (step_w),
    .last_o   (last_w)
  );

  epc_busy_timer #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .start_i  (last_w),
    .active_o (hold_w)
  );

  // step k reads offset k and writes offset k-1 (read data returns one clock later)
  assign rd_off_w    = step_w[PAGE_AW-1:0];
  assign wr_off_w    = PAGE_AW'(step_w - 1'b1);
  assign arr_re_o    = commit_w && !step_w[PAGE_AW] && !dirty_w[rd_off_w];
  assign arr_raddr_o = {base_w, rd_off_w};
  assign arr_we_o    = commit_w && (step_w != '0);
  assign arr_waddr_o = {base_w, wr_off_w};
  assign arr_wdata_o = dirty_w[wr_off_w] ? buf_byte_w : arr_rdata_i;

  // R5: consecutive commit writes walk up the page one offset at a time
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (arr_we_o && $past(arr_we_o)) |-> (arr_waddr_o == $past(arr_waddr_o) + 1'b1));

  // R6: an end strobe on a protected page never leads to busy
  a_r6_prot_quiet: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (stop_acc_w && prot_w) |=> !busy_o);

  // R8: the page under commit cannot be replaced while busy
  a_r8_base_frozen: assert property (@(posedge clk) disable iff (!rst_sync_q)
    busy_o |=> $stable(base_w));

  // R9: an end strobe with nothing received leaves the block idle
  a_r9_empty_stop: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (stop_acc_w && (dirty_w == '0)) |=> !busy_o);

  // R4: no array write happens in the cycle after a byte is collected
  a_r4_no_early_write: assert property (@(posedge clk) disable iff (!rst_sync_q)
    data_acc_w |=> !arr_we_o);
endmodule

// File: tb/eeprom_page_commit_bench.sv
`timescale 1ns/1ps
module eeprom_page_commit_bench;
  localparam int B = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [14:0] cmd_addr = '0;
  logic        data_valid = 1'b0;
  logic [7:0]  data = '0;
  logic        stop = 1'b0;
  logic        busy_o, arr_re_o, arr_we_o;
  logic [14:0] arr_raddr_o, arr_waddr_o;
  logic [7:0]  arr_rdata, arr_wdata_o;

  always #10 clk = ~clk;

  eeprom_page_commit #(.BUSY_CYCLES(B)) u_eeprom_page_commit (
    .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start), .cmd_addr_i(cmd_addr),
    .data_valid_i(data_valid), .data_i(data), .stop_i(stop), .busy_o(busy_o),
    .arr_re_o(arr_re_o), .arr_raddr_o(arr_raddr_o), .arr_rdata_i(arr_rdata),
    .arr_we_o(arr_we_o), .arr_waddr_o(arr_waddr_o), .arr_wdata_o(arr_wdata_o));

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";
  bit done = 0;

  // sparse array model with a computed initial pattern
  bit [7:0] mem [int];
  function automatic int memrd(int a);
    if (mem.exists(a)) return int'(mem[a]);
    return (a * 13 + 5) & 255;
  endfunction

  always @(posedge clk) begin
    if (arr_re_o) arr_rdata <= 8'(memrd(int'(arr_raddr_o)));
    if (arr_we_o) mem[int'(arr_waddr_o)] = arr_wdata_o;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model, updated on the same edge the design samples
  int       m_t = -1;
  bit       m_open = 0;
  int       m_base = 0, m_ptr = 0;
  bit [63:0] m_dirty = '0;
  int       m_buf [64];
  int       exp_page [64];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t = -1; m_open = 0;
    end else if (m_t >= 0) begin
      m_t++;
      if (m_t == 65 + B) m_t = -1;
    end else if (stop) begin
      if (m_open && m_dirty != 0 && m_base * 64 < 'h7000) begin
        for (int o = 0; o < 64; o++)
          exp_page[o] = m_dirty[o] ? m_buf[o] : memrd(m_base * 64 + o);
        m_t = 0;
      end
      m_open = 0;
    end else if (cmd_start) begin
      m_open = 1; m_base = int'(cmd_addr) / 64; m_ptr = int'(cmd_addr) % 64; m_dirty = '0;
    end else if (data_valid && m_open) begin
      m_buf[m_ptr] = int'(data); m_dirty[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 64;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "busy", int'(busy_o), int'(m_t >= 0));
      chk(cur_req, "arr_we", int'(arr_we_o), int'(m_t >= 1 && m_t <= 64));
      if (m_t >= 1 && m_t <= 64) begin
        chk(cur_req, "arr_waddr", int'(arr_waddr_o), m_base * 64 + m_t - 1);
        chk(cur_req, "arr_wdata", int'(arr_wdata_o), exp_page[m_t - 1]);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic pulse_clear();
    @(negedge clk);
    cmd_start = 0; data_valid = 0; stop = 0;
  endtask
  task automatic do_start(int a);
    @(negedge clk); cmd_start = 1; cmd_addr = 15'(a);
    pulse_clear();
  endtask
  task automatic do_byte(int d);
    @(negedge clk); data_valid = 1; data = 8'(d);
    pulse_clear();
  endtask
  task automatic do_stop();
    @(negedge clk); stop = 1;
    pulse_clear();
  endtask
  task automatic wait_idle();
    while (m_t >= 0 || busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R10", "busy in reset", int'(busy_o), 0);
    chk("R10", "we in reset", int'(arr_we_o), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R10", "busy after reset", int'(busy_o), 0);
    chk("R10", "re after reset", int'(arr_re_o), 0);

    // R1 / R4 / R5 / R7: short write at start of page
    cur_req = "R4";
    do_start('h0100); do_byte('hA1); do_byte('hA2); do_byte('hA3);
    chk("R4", "no write before stop", int'(arr_we_o), 0);
    chk("R4", "array untouched before stop", memrd('h0100), ('h0100 * 13 + 5) & 255);
    cur_req = "R5";
    do_stop();
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    chk("R7", "busy length", n, 65 + B);
    wait_idle();
    chk("R1", "offset 0", memrd('h0100), 'hA1);
    chk("R1", "offset 1", memrd('h0101), 'hA2);
    chk("R1", "offset 2", memrd('h0102), 'hA3);
    chk("R5", "refreshed offset 3", memrd('h0103), ('h0103 * 13 + 5) & 255);
    chk("R5", "refreshed offset 63", memrd('h013F), ('h013F * 13 + 5) & 255);

    // R3: mid-page start wraps inside the same page
    cur_req = "R3";
    do_start('h013E); do_byte('h11); do_byte('h22); do_byte('h33); do_byte('h44);
    do_stop(); wait_idle();
    chk("R3", "offset 3E", memrd('h013E), 'h11);
    chk("R3", "offset 3F", memrd('h013F), 'h22);
    chk("R3", "wrapped offset 0", memrd('h0100), 'h33);
    chk("R3", "wrapped offset 1", memrd('h0101), 'h44);
    chk("R3", "next page untouched", memrd('h0140), ('h0140 * 13 + 5) & 255);
    chk("R5", "kept earlier byte", memrd('h0102), 'hA3);

    // R2: 66 bytes overwrite the first two
    cur_req = "R2";
    do_start('h0200);
    for (int i = 0; i < 66; i++) do_byte((i * 3 + 1) & 255);
    do_stop(); wait_idle();
    chk("R2", "offset 0 overwritten", memrd('h0200), 193);
    chk("R2", "offset 1 overwritten", memrd('h0201), 196);
    chk("R2", "offset 2 kept", memrd('h0202), 7);
    chk("R2", "offset 63", memrd('h023F), 190);
    chk("R2", "next page untouched", memrd('h0240), ('h0240 * 13 + 5) & 255);

    // R6: protection boundary
    cur_req = "R6";
    do_start('h7000); do_byte('h55); do_byte('h66); do_stop();
    chk("R6", "no busy on protected page", int'(busy_o), 0);
    repeat (70) @(negedge clk);
    chk("R6", "protected byte unchanged", memrd('h7000), ('h7000 * 13 + 5) & 255);
    do_start('h6FC0); do_byte('h77); do_stop(); wait_idle();
    chk("R6", "last writable page written", memrd('h6FC0), 'h77);

    // R8: strobes during busy are ignored
    cur_req = "R8";
    do_start('h0300); do_byte('h05); do_stop();
    do_start('h0400); do_byte('h09); do_stop();
    wait_idle();
    chk("R8", "ignored page untouched", memrd('h0400), ('h0400 * 13 + 5) & 255);
    chk("R8", "committed byte", memrd('h0300), 'h05);

    // R9: orphan data, empty stop, replaced command
    cur_req = "R9";
    do_byte('hEE); do_stop();
    chk("R9", "orphan byte no commit", int'(busy_o), 0);
    do_start('h0500); do_stop();
    chk("R9", "empty stop no commit", int'(busy_o), 0);
    do_start('h0600); do_byte('h12); do_start('h0700); do_byte('h34);
    do_stop(); wait_idle();
    chk("R9", "discarded page untouched", memrd('h0600), ('h0600 * 13 + 5) & 255);
    chk("R9", "replacement written", memrd('h0700), 'h34);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule